// File: doc/BRIEF.md
# Filtered Event Counter Bank

This block holds ten 32-bit event counters behind a word-addressed register port. Counters 0 to 7 form a slow group that may only advance in cycles where a half-rate enable strobe is high; counters 8 and 9 form a fast group that may advance on every clock. Each counter has a control word that enables it, picks one event input through a code field, optionally inverts that event, and chooses how much one qualifying cycle adds.

Every counter also carries a private 45-bit mask and match pair, which is compared against a shared attribute bus. A cycle only counts when the masked attribute bits equal the masked match bits. When a counter wraps past its all-ones value, a sticky flag for it is set in its group's overflow register, and a level interrupt stays high while any flag in either group is set. Software clears flags by writing zeros to them, and it can preload a counter value at any time.

Top module: `efc_bank`

## Requirements
- R1: After reset every counter value, control word, mask, match and overflow flag reads zero and `irq_o` is low.
- R2: Counter n owns the word addresses 0x10 + 0x28*n plus: mask bits 31:0 at +0x0, mask bits 44:32 at +0x4, match bits 31:0 at +0x8, match bits 44:32 at +0xC, control at +0x10, value at +0x20. High words keep only bits 12:0, and control reads back only bits 8:0; other bits read zero.
- R3: Counters 0 to 7 change only in cycles where `half_stb_i` is high; counters 8 and 9 may change in every cycle.
- R4: Control bits 6:2 hold the event code. Code 0 is an event in every cycle. Code k (1 to 25 in the slow group, 1 to 2 in the fast group) takes `evt_half_i[k]` or `evt_full_i[k]`. Any larger code is never an event.
- R5: Control bit 1 inverts the selected event before it is qualified.
- R6: A cycle qualifies only when ((attr_i XOR match) AND mask) is zero over the 45 attribute bits; a mask of zero lets every cycle through.
- R7: Control bits 8:7 set the step: value 1 adds the group's `amt_*_i` input per qualifying cycle; values 0, 2 and 3 add one.
- R8: With control bit 0 clear the counter keeps its value.
- R9: A write to the value register takes effect at the next edge even when the counter would also have advanced in that cycle.
- R10: When a counter wraps past 0xFFFFFFFF, flag bit n of the register at 0x8 is set for counters 0 to 7, and flag bit n-8 of the register at 0xC for counters 8 and 9.
- R11: A write to an overflow register clears each flag whose data bit is 0 and keeps each flag whose data bit is 1, so writing zero clears the register. A wrap in the same cycle as a clearing write leaves its flag set.
- R12: `irq_o` is high exactly while at least one flag in either overflow register is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_stb_i | input | 1 | Half-rate enable for counters 0 to 7 |
| evt_half_i | input | 25 | Slow-group event inputs, bit k is code k (bits 25:1) |
| evt_full_i | input | 2 | Fast-group event inputs, bit k is code k (bits 2:1) |
| amt_half_i | input | 8 | Step amount for slow-group counters in amount mode |
| amt_full_i | input | 8 | Step amount for fast-group counters in amount mode |
| attr_i | input | 45 | Attribute bus compared under mask and match |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i`, same cycle |
| irq_o | output | 1 | Overflow interrupt level |

## Verification
The bench drives a counter to wrap on exactly the edge where software writes zero to its overflow register; a design that gave the write priority would lose that flag and drop the interrupt. It preloads values near all-ones in both groups so a design that mixed up the two flag registers, or put fast-group flags at bit n instead of n-8, reads back the wrong word. It writes ones above bit 44 of a mask to show they cannot block counting, and it uses event codes past the end of each group's list, where a design that indexed out of range would count stray inputs. A value write into a running counter shows whether the increment wrongly overrides the preload.

// File: rtl/efc_pkg.sv
package efc_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned SEL_W      = 5;
    localparam int unsigned STAT0_OFS  = 'h8;
    localparam int unsigned STAT1_OFS  = 'hC;
    localparam int unsigned GRP_BASE   = 'h10;
    localparam int unsigned GRP_STRIDE = 'h28;
    localparam int unsigned OFS_MASK_LO  = 'h00;
    localparam int unsigned OFS_MASK_HI  = 'h04;
    localparam int unsigned OFS_MATCH_LO = 'h08;
    localparam int unsigned OFS_MATCH_HI = 'h0C;
    localparam int unsigned OFS_CTRL     = 'h10;
    localparam int unsigned OFS_VALUE    = 'h20;

    typedef enum logic [1:0] {
        STEP_ONE  = 2'd0,
        STEP_AMT  = 2'd1,
        STEP_RSV2 = 2'd2,
        STEP_RSV3 = 2'd3
    } step_mode_e;

    // Packed from bit 8 down to bit 0 of the control word.
    typedef struct packed {
        step_mode_e       mode;
        logic [SEL_W-1:0] sel;
        logic             inv;
        logic             en;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    typedef enum logic [2:0] {
        FLD_NONE,
        FLD_MASK_LO,
        FLD_MASK_HI,
        FLD_MATCH_LO,
        FLD_MATCH_HI,
        FLD_CTRL,
        FLD_VALUE
    } field_e;

endpackage

// File: rtl/efc_regdec.sv
module efc_regdec
    import efc_pkg::*;
#(
    parameter int unsigned N_CNT  = 10,
    parameter int unsigned ADDR_W = 12,
    localparam int unsigned IDX_W = (N_CNT > 1) ? $clog2(N_CNT) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_st0_o,
    output logic              hit_st1_o,
    output logic              hit_cnt_o,
    output logic [IDX_W-1:0]  idx_o,
    output field_e            field_o
);

    logic [ADDR_W-1:0] off;
    logic [ADDR_W-1:0] grp;
    logic [ADDR_W-1:0] sub;

    always_comb begin
        hit_st0_o = (addr_i == ADDR_W'(STAT0_OFS));
        hit_st1_o = (addr_i == ADDR_W'(STAT1_OFS));
        off       = addr_i - ADDR_W'(GRP_BASE);
        grp       = off / ADDR_W'(GRP_STRIDE);
        sub       = off - grp * ADDR_W'(GRP_STRIDE);
        idx_o     = grp[IDX_W-1:0];
        case (sub)
            ADDR_W'(OFS_MASK_LO):  field_o = FLD_MASK_LO;
            ADDR_W'(OFS_MASK_HI):  field_o = FLD_MASK_HI;
            ADDR_W'(OFS_MATCH_LO): field_o = FLD_MATCH_LO;
            ADDR_W'(OFS_MATCH_HI): field_o = FLD_MATCH_HI;
            ADDR_W'(OFS_CTRL):     field_o = FLD_CTRL;
            ADDR_W'(OFS_VALUE):    field_o = FLD_VALUE;
            default:               field_o = FLD_NONE;
        endcase
        hit_cnt_o = (addr_i >= ADDR_W'(GRP_BASE)) && (grp < ADDR_W'(N_CNT))
                    && (field_o != FLD_NONE);
    end

endmodule

// File: rtl/efc_counter.sv
module efc_counter
    import efc_pkg::*;
#(
    parameter int unsigned N_EVT  = 26,
    parameter int unsigned ATTR_W = 45,
    parameter int unsigned AMT_W  = 8,
    localparam int unsigned HI_W  = ATTR_W - WORD_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              stb_i,
    input  logic [N_EVT-1:1]  evt_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic [ATTR_W-1:0] attr_i,
    input  logic              wr_i,
    input  field_e            field_i,
    input  logic [WORD_W-1:0] wdata_i,
    output ctrl_t             ctrl_o,
    output logic [ATTR_W-1:0] mask_o,
    output logic [ATTR_W-1:0] match_o,
    output logic [WORD_W-1:0] value_o,
    output logic              ovf_o
);

    typedef struct packed {
        logic [ATTR_W-1:0] mask;
        logic [ATTR_W-1:0] match;
        ctrl_t             ctrl;
        logic [WORD_W-1:0] value;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    logic [(1<<SEL_W)-1:0] evt_pad;
    logic                  raw_evt;
    logic                  qual;
    logic                  hit;
    logic [WORD_W-1:0]     step;
    logic [WORD_W:0]       sum;

    always_comb begin
        state_d = state_q;

        evt_pad          = '0;
        evt_pad[N_EVT-1:1] = evt_i;
        evt_pad[0]       = 1'b1;
        raw_evt          = evt_pad[state_q.ctrl.sel];

        qual = ((attr_i ^ state_q.match) & state_q.mask) == '0;
        hit  = state_q.ctrl.en & stb_i & (raw_evt ^ state_q.ctrl.inv) & qual;
        step = (state_q.ctrl.mode == STEP_AMT) ? WORD_W'(amt_i) : WORD_W'(1);
        sum  = {1'b0, state_q.value} + {1'b0, step};

        ovf_o = hit & sum[WORD_W];
        if (hit) begin
            state_d.value = sum[WORD_W-1:0];
        end

        if (wr_i) begin
            case (field_i)
                FLD_MASK_LO:  state_d.mask[WORD_W-1:0]       = wdata_i;
                FLD_MASK_HI:  state_d.mask[ATTR_W-1:WORD_W]  = wdata_i[HI_W-1:0];
                FLD_MATCH_LO: state_d.match[WORD_W-1:0]      = wdata_i;
                FLD_MATCH_HI: state_d.match[ATTR_W-1:WORD_W] = wdata_i[HI_W-1:0];
                FLD_CTRL:     state_d.ctrl  = ctrl_t'(wdata_i[CTRL_W-1:0]);
                FLD_VALUE:    state_d.value = wdata_i;
                default:      ;
            endcase
        end

        ctrl_o  = state_q.ctrl;
        mask_o  = state_q.mask;
        match_o = state_q.match;
        value_o = state_q.value;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/efc_ovf_status.sv
module efc_ovf_status #(
    parameter int unsigned N_BITS = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_BITS-1:0] set_i,
    input  logic              wr_i,
    input  logic [N_BITS-1:0] wdata_i,
    output logic [N_BITS-1:0] flags_o
);

    typedef struct packed {
        logic [N_BITS-1:0] flags;
    } st_state_t;

    st_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_i) begin
            state_d.flags = state_q.flags & wdata_i;
        end
        // Hardware set is applied last so it survives a clearing write.
        state_d.flags = state_d.flags | set_i;
        flags_o = state_q.flags;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/efc_bank.sv
module efc_bank
    import efc_pkg::*;
#(
    parameter int unsigned N_HALF     = 8,
    parameter int unsigned N_FULL     = 2,
    parameter int unsigned N_EVT_HALF = 26,
    parameter int unsigned N_EVT_FULL = 3,
    parameter int unsigned ATTR_W     = 45,
    parameter int unsigned AMT_W      = 8,
    parameter int unsigned ADDR_W     = 12
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  half_stb_i,
    input  logic [N_EVT_HALF-1:1] evt_half_i,
    input  logic [N_EVT_FULL-1:1] evt_full_i,
    input  logic [AMT_W-1:0]      amt_half_i,
    input  logic [AMT_W-1:0]      amt_full_i,
    input  logic [ATTR_W-1:0]     attr_i,
    input  logic                  reg_we_i,
    input  logic [ADDR_W-1:0]     reg_addr_i,
    input  logic [WORD_W-1:0]     reg_wdata_i,
    output logic [WORD_W-1:0]     reg_rdata_o,
    output logic                  irq_o
);

    localparam int unsigned N_CNT = N_HALF + N_FULL;
    localparam int unsigned IDX_W = (N_CNT > 1) ? $clog2(N_CNT) : 1;
    localparam int unsigned HI_W  = ATTR_W - WORD_W;

    logic              hit_st0, hit_st1, hit_cnt;
    logic [IDX_W-1:0]  cnt_idx;
    field_e            field;

    ctrl_t                        ctrl_w  [N_CNT];
    logic [ATTR_W-1:0]            mask_w  [N_CNT];
    logic [ATTR_W-1:0]            match_w [N_CNT];
    logic [N_CNT-1:0][WORD_W-1:0] val_w;
    logic [N_CNT-1:0]             ovf_w;
    logic [N_CNT-1:0]             en_w;
    logic [N_HALF-1:0]            st0_w;
    logic [N_FULL-1:0]            st1_w;

    efc_regdec #(
        .N_CNT  (N_CNT),
        .ADDR_W (ADDR_W)
    ) i_regdec (
        .addr_i    (reg_addr_i),
        .hit_st0_o (hit_st0),
        .hit_st1_o (hit_st1),
        .hit_cnt_o (hit_cnt),
        .idx_o     (cnt_idx),
        .field_o   (field)
    );

    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
        logic cnt_wr;
        assign cnt_wr = reg_we_i && hit_cnt && (cnt_idx == IDX_W'(i));
        assign en_w[i] = ctrl_w[i].en;
        if (i < N_HALF) begin : g_half
            efc_counter #(
                .N_EVT  (N_EVT_HALF),
                .ATTR_W (ATTR_W),
                .AMT_W  (AMT_W)
            ) i_counter (
                .clk_i   (clk_i),
                .rst_ni  (rst_ni),
                .stb_i   (half_stb_i),
                .evt_i   (evt_half_i),
                .amt_i   (amt_half_i),
                .attr_i  (attr_i),
                .wr_i    (cnt_wr),
                .field_i (field),
                .wdata_i (reg_wdata_i),
                .ctrl_o  (ctrl_w[i]),
                .mask_o  (mask_w[i]),
                .match_o (match_w[i]),
                .value_o (val_w[i]),
                .ovf_o   (ovf_w[i])
            );
        end else begin : g_full
            efc_counter #(
                .N_EVT  (N_EVT_FULL),
                .ATTR_W (ATTR_W),
                .AMT_W  (AMT_W)
            ) i_counter (
                .clk_i   (clk_i),
                .rst_ni  (rst_ni),
                .stb_i   (1'b1),
                .evt_i   (evt_full_i),
                .amt_i   (amt_full_i),
                .attr_i  (attr_i),
                .wr_i    (cnt_wr),
                .field_i (field),
                .wdata_i (reg_wdata_i),
                .ctrl_o  (ctrl_w[i]),
                .mask_o  (mask_w[i]),
                .match_o (match_w[i]),
                .value_o (val_w[i]),
                .ovf_o   (ovf_w[i])
            );
        end
    end

    efc_ovf_status #(
        .N_BITS (N_HALF)
    ) i_st_half (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (ovf_w[N_HALF-1:0]),
        .wr_i    (reg_we_i && hit_st0),
        .wdata_i (reg_wdata_i[N_HALF-1:0]),
        .flags_o (st0_w)
    );

    efc_ovf_status #(
        .N_BITS (N_FULL)
    ) i_st_full (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (ovf_w[N_CNT-1:N_HALF]),
        .wr_i    (reg_we_i && hit_st1),
        .wdata_i (reg_wdata_i[N_FULL-1:0]),
        .flags_o (st1_w)
    );

    assign irq_o = (|st0_w) | (|st1_w);

    always_comb begin
        reg_rdata_o = '0;
        if (hit_st0) begin
            reg_rdata_o[N_HALF-1:0] = st0_w;
        end else if (hit_st1) begin
            reg_rdata_o[N_FULL-1:0] = st1_w;
        end else if (hit_cnt) begin
            case (field)
                FLD_MASK_LO:  reg_rdata_o = mask_w[cnt_idx][WORD_W-1:0];
                FLD_MASK_HI:  reg_rdata_o[HI_W-1:0] = mask_w[cnt_idx][ATTR_W-1:WORD_W];
                FLD_MATCH_LO: reg_rdata_o = match_w[cnt_idx][WORD_W-1:0];
                FLD_MATCH_HI: reg_rdata_o[HI_W-1:0] = match_w[cnt_idx][ATTR_W-1:WORD_W];
                FLD_CTRL:     reg_rdata_o[CTRL_W-1:0] = ctrl_w[cnt_idx];
                FLD_VALUE:    reg_rdata_o = val_w[cnt_idx];
                default:      reg_rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/efc_bank_chk.sv
module efc_bank_chk #(
    parameter int unsigned N_HALF = 8,
    parameter int unsigned N_FULL = 2,
    localparam int unsigned N_CNT = N_HALF + N_FULL
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   half_stb_i,
    input logic                   reg_we_i,
    input logic                   irq_o,
    input logic [N_CNT-1:0]       ovf_i,
    input logic [N_CNT-1:0]       en_i,
    input logic [N_CNT-1:0][31:0] val_i,
    input logic [N_HALF-1:0]      st0_i,
    input logic [N_FULL-1:0]      st1_i
);

    // R12: the interrupt only drops after a register write
    a_r12_irq_fall_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(irq_o) |-> $past(reg_we_i));

    // R12: the interrupt only rises after a counter wrapped
    a_r12_irq_rise_after_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> $past(|ovf_i));

    for (genvar i = 0; i < N_CNT; i++) begin : g_chk
        // R8: a disabled counter keeps its value unless software writes
        a_r8_disabled_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!en_i[i] && !reg_we_i) |=> $stable(val_i[i]));
        if (i < N_HALF) begin : g_half
            // R3: slow-group counters stand still without the strobe
            a_r3_half_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (!half_stb_i && !reg_we_i) |=> $stable(val_i[i]));
            // R10, R11: a wrap leaves its flag set in group 0
            a_r10_flag_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
                ovf_i[i] |=> st0_i[i]);
        end else begin : g_full
            // R10, R11: a wrap leaves its flag set in group 1
            a_r10_flag_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
                ovf_i[i] |=> st1_i[i-N_HALF]);
        end
    end

endmodule

bind efc_bank efc_bank_chk #(
    .N_HALF (N_HALF),
    .N_FULL (N_FULL)
) i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .half_stb_i (half_stb_i),
    .reg_we_i   (reg_we_i),
    .irq_o      (irq_o),
    .ovf_i      (ovf_w),
    .en_i       (en_w),
    .val_i      (val_w),
    .st0_i      (st0_w),
    .st1_i      (st1_w)
);

// File: tb/test_efc_bank.sv
module test_efc_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        half_stb = 1'b0;
    logic [25:1] evt_half = '0;
    logic [2:1]  evt_full = '0;
    logic [7:0]  amt_half = '0;
    logic [7:0]  amt_full = '0;
    logic [44:0] attr = '0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_cmp = 0;
    int n_err = 0;
    bit done = 1'b0;

    efc_bank i_efc_bank (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .half_stb_i  (half_stb),
        .evt_half_i  (evt_half),
        .evt_full_i  (evt_full),
        .amt_half_i  (amt_half),
        .amt_full_i  (amt_full),
        .attr_i      (attr),
        .reg_we_i    (reg_we),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_o       (irq)
    );

    always #10ns clk = ~clk;

    localparam logic [11:0] A_ST0 = 12'h008;
    localparam logic [11:0] A_ST1 = 12'h00C;

    function automatic logic [11:0] ca(input int n, input int ofs);
        return 12'(16 + 40 * n + ofs);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
        reg_addr = a;
        #1ns;
        chk(req, reg_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobes(input int n, input bit alternate);
        for (int k = 0; k < n; k++) begin
            half_stb = alternate ? ~k[0] : 1'b1;
            @(negedge clk);
        end
        half_stb = 1'b0;
    endtask

    task automatic t_reset;
        rd(ca(0, 'h10), 0, "R1 ctrl0");
        rd(ca(3, 'h20), 0, "R1 value3");
        rd(ca(9, 'h00), 0, "R1 mask9");
        rd(A_ST0, 0, "R1 st0");
        rd(A_ST1, 0, "R1 st1");
        chk("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_regmap;
        wr(ca(5, 'h04), 32'hFFFF_FFFF);
        rd(ca(5, 'h04), 32'h0000_1FFF, "R2 mask hi width");
        wr(ca(5, 'h10), 32'hFFFF_FFFF);
        rd(ca(5, 'h10), 32'h0000_01FF, "R2 ctrl width");
        wr(ca(9, 'h08), 32'h1234_5678);
        rd(ca(9, 'h08), 32'h1234_5678, "R2 match lo c9");
        rd(ca(9, 'h14), 0, "R2 hole reads zero");
        wr(ca(5, 'h10), 0);
        wr(ca(5, 'h04), 0);
        wr(ca(9, 'h08), 0);
    endtask

    task automatic t_half_cycles;
        wr(ca(0, 'h10), 32'h1);
        strobes(12, 1'b1);
        wr(ca(0, 'h10), 0);
        rd(ca(0, 'h20), 6, "R3 R4 half cycle count");
    endtask

    task automatic t_full_cycles;
        wr(ca(8, 'h10), 32'h1);
        idle(5);
        wr(ca(8, 'h10), 0);
        rd(ca(8, 'h20), 6, "R3 full cycle count");
    endtask

    task automatic t_event_sel;
        bit pat [8] = '{1, 1, 0, 1, 0, 0, 1, 0};
        wr(ca(1, 'h10), 32'h0D);
        wr(ca(2, 'h10), 32'h0F);
        wr(ca(3, 'h10), 32'h69);
        wr(ca(9, 'h10), 32'h0D);
        for (int k = 0; k < 8; k++) begin
            half_stb = 1'b1;
            evt_half[3] = pat[k];
            evt_half[4] = ~pat[k];
            evt_full[2] = 1'b1;
            @(negedge clk);
        end
        half_stb = 1'b0; evt_half = '0; evt_full = '0;
        wr(ca(1, 'h10), 0);
        wr(ca(2, 'h10), 0);
        wr(ca(3, 'h10), 0);
        wr(ca(9, 'h10), 0);
        rd(ca(1, 'h20), 4, "R4 code 3 count");
        rd(ca(2, 'h20), 4, "R5 inverted count");
        rd(ca(3, 'h20), 0, "R4 code 26 never");
        rd(ca(9, 'h20), 0, "R4 full code 3 never");
    endtask

    task automatic t_mask;
        wr(ca(4, 'h04), 32'h100);
        wr(ca(4, 'h0C), 32'h100);
        wr(ca(5, 'h00), 32'hF0);
        wr(ca(5, 'h08), 32'hA0);
        wr(ca(6, 'h04), 32'hFFFF_E000);
        rd(ca(6, 'h04), 0, "R2 R6 mask bits above 44 dropped");
        wr(ca(4, 'h10), 32'h1);
        wr(ca(5, 'h10), 32'h1);
        wr(ca(6, 'h10), 32'h1);
        for (int k = 0; k < 8; k++) begin
            half_stb = 1'b1;
            attr = '0;
            attr[40] = (k < 3);
            attr[7:0] = (k < 5) ? 8'hA5 : 8'hB0;
            @(negedge clk);
        end
        half_stb = 1'b0; attr = '0;
        wr(ca(4, 'h10), 0);
        wr(ca(5, 'h10), 0);
        wr(ca(6, 'h10), 0);
        rd(ca(4, 'h20), 3, "R6 high word qualifier");
        rd(ca(5, 'h20), 5, "R6 low word qualifier");
        rd(ca(6, 'h20), 8, "R6 empty mask");
    endtask

    task automatic t_incr;
        amt_half = 8'd5;
        amt_full = 8'd3;
        wr(ca(0, 'h20), 0);
        wr(ca(7, 'h10), 32'h081);
        wr(ca(0, 'h10), 32'h101);
        strobes(4, 1'b0);
        wr(ca(7, 'h10), 0);
        wr(ca(0, 'h10), 0);
        rd(ca(7, 'h20), 20, "R7 amount step half");
        rd(ca(0, 'h20), 4, "R7 reserved mode steps one");
        wr(ca(8, 'h20), 0);
        wr(ca(8, 'h10), 32'h081);
        idle(3);
        wr(ca(8, 'h10), 0);
        rd(ca(8, 'h20), 12, "R7 amount step full");
        amt_half = '0; amt_full = '0;
    endtask

    task automatic t_hold_write;
        strobes(6, 1'b0);
        rd(ca(7, 'h20), 20, "R8 disabled holds");
        wr(ca(8, 'h10), 32'h1);
        wr(ca(8, 'h20), 32'h100);
        rd(ca(8, 'h20), 32'h100, "R9 write beats increment");
        wr(ca(8, 'h10), 0);
        rd(ca(8, 'h20), 32'h101, "R9 counts on after preload");
    endtask

    task automatic t_overflow;
        wr(ca(2, 'h20), 32'hFFFF_FFFE);
        wr(ca(2, 'h10), 32'h1);
        strobes(4, 1'b0);
        wr(ca(2, 'h10), 0);
        rd(ca(2, 'h20), 2, "R10 wrapped value");
        rd(A_ST0, 32'h04, "R10 group 0 flag");
        chk("R12 irq after wrap", {31'b0, irq}, 1);
        wr(ca(9, 'h20), 32'hFFFF_FFFF);
        wr(ca(9, 'h10), 32'h1);
        wr(ca(9, 'h10), 0);
        rd(ca(9, 'h20), 0, "R10 full wrap value");
        rd(A_ST1, 32'h02, "R10 group 1 flag at n-8");
    endtask

    task automatic t_clear;
        wr(A_ST1, 32'hFF);
        rd(A_ST1, 32'h02, "R11 ones keep flags");
        wr(A_ST0, 32'hFB);
        rd(A_ST0, 0, "R11 zero bit clears");
        chk("R12 irq held by group 1", {31'b0, irq}, 1);
        wr(A_ST1, 0);
        rd(A_ST1, 0, "R11 zero clears group 1");
        chk("R12 irq low when clear", {31'b0, irq}, 0);
    endtask

    task automatic t_collide;
        wr(ca(8, 'h10), 32'h1);
        wr(ca(8, 'h20), 32'hFFFF_FFFE);
        idle(1);
        wr(A_ST1, 0);
        wr(ca(8, 'h10), 0);
        rd(A_ST1, 32'h01, "R11 wrap beats clearing write");
        rd(ca(8, 'h20), 1, "R10 value after collide");
        chk("R12 irq after collide", {31'b0, irq}, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_half_cycles();
        t_full_cycles();
        t_event_sel();
        t_mask();
        t_incr();
        t_hold_write();
        t_overflow();
        t_clear();
        t_collide();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_err++;
            $display("FAIL watchdog: actual still running, expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end

endmodule